// File: doc/BRIEF.md
# Coherence Response Flit Receiver

This block sits beside a last-level cache slice. It takes coherence traffic that travels from the processor caches toward memory. The traffic arrives as 33-bit flits on a valid/ready stream. Two packet kinds share the stream:

- **Cleanup requests** are two flits long. The first flit is a header. The second flit carries the low part of the cache line number.
- **Multi-acknowledges** are a single flit.

The block splits each header into its fields. For a cleanup, it rebuilds the 34-bit line number from the two bits in the header and the 32 bits in the second flit. It then presents the result on one of two output ports, one per packet kind. Each output port has its own valid/ready handshake and holds its value until that handshake completes.

Framing faults raise a sticky error flag, and the offending flit is dropped. The faults are:

- a header whose end-of-packet bit does not match its packet kind;
- a header with the broadcast bit set;
- a second cleanup flit without end-of-packet.

After a fault the parser waits for a new header. The block does not update a directory and keeps no table of outstanding updates. Downstream logic does that work.

Top module: `cohrsp_rx`

## Requirements
- R1: After reset, `cln_valid`, `ack_valid` and `err_flag` are 0 and `in_ready` is 1.
- R2: In a header flit, bit 32 is end-of-packet, [31:22] is the destination, [21:8] is the source, [7:6] are the line-number high bits, [4:3] is the way, [2:1] is the type and bit 0 is the broadcast flag. Type bit 2 set (codes 10 and 11) marks a cleanup. After a cleanup header with bit 32 clear and a second flit with bit 32 set, the cleanup port shows:
  - `cln_line` = {header[7:6], second[31:0]};
  - `cln_instr` = header bit 1, which is 0 for type 10 (data line) and 1 for type 11 (instruction line);
  - the destination, source and way fields as listed above.
- R3: After only the first flit of a cleanup has been accepted, `cln_valid` stays 0.
- R4: A header with type bit 2 clear and bit 32 set is a multi-acknowledge. It drives `ack_valid` with `ack_dest`=[31:22], `ack_src`=[21:8] and `ack_idx`=[6:3]. Header bit 1 has no effect.
- R5: A valid output keeps its fields stable until its ready is high. While either output is valid, `in_ready` is 0. An output is valid one cycle after the flit that completes its packet is accepted.
- R6: A cleanup header with bit 32 set sets `err_flag`, produces no output, and is dropped. The next flit is taken as a header.
- R7: A multi-acknowledge header with bit 32 clear sets `err_flag`, produces no output, and is dropped.
- R8: A header with bit 0 set sets `err_flag` and is dropped. Bit 0 of a second cleanup flit is line data, not a broadcast flag.
- R9: A second cleanup flit with bit 32 clear sets `err_flag` and discards the whole cleanup. The next flit is taken as a header.
- R10: `err_flag` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Receiver can accept a flit |
| in_flit | input | 33 | Incoming flit |
| cln_valid | output | 1 | Cleanup result valid |
| cln_ready | input | 1 | Cleanup result taken |
| cln_dest | output | 10 | Cleanup destination |
| cln_src | output | 14 | Cleanup source |
| cln_way | output | 2 | Cleanup way |
| cln_instr | output | 1 | 1 for instruction line, 0 for data line |
| cln_line | output | 34 | Rebuilt line number |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_ready | input | 1 | Acknowledge result taken |
| ack_dest | output | 10 | Acknowledge destination |
| ack_src | output | 14 | Acknowledge source |
| ack_idx | output | 4 | Update-table index |
| err_flag | output | 1 | Sticky framing error |

## Verification
The assertions check these on every cycle:
- output stability under back-pressure;
- the input stall while a result is pending;
- that the two outputs are never valid together;
- that a cleanup result appears only right after a second flit;
- that the error flag persists.

Field placement, line-number reassembly, and the recovery after each kind of framing fault depend on chosen flit contents. Only the directed scenarios show those, for example a header flagged bad followed by a good acknowledge.

// File: rtl/cohrsp_pkg.sv
package cohrsp_pkg;
  localparam int FLIT_W   = 33;
  localparam int DEST_W   = 10;
  localparam int SRC_W    = 14;
  localparam int HI_W     = 2;
  localparam int LO_W     = FLIT_W - 1;
  localparam int LINE_W   = HI_W + LO_W;
  localparam int WAY_W    = 2;
  localparam int IDX_W    = 4;
  localparam int TYPE_W   = 2;

  localparam int EOP_POS  = FLIT_W - 1;
  localparam int BC_POS   = 0;
  localparam int TYPE_LSB = BC_POS + 1;
  localparam int WAY_LSB  = TYPE_LSB + TYPE_W;
  localparam int IDX_LSB  = TYPE_LSB + TYPE_W;
  localparam int HI_LSB   = WAY_LSB + WAY_W + 1;
  localparam int SRC_LSB  = HI_LSB + HI_W;
  localparam int DEST_LSB = SRC_LSB + SRC_W;

  typedef struct packed {
    logic              eop;
    logic              bc;
    logic              is_cln;
    logic              instr;
    logic [DEST_W-1:0] dest;
    logic [SRC_W-1:0]  src;
    logic [HI_W-1:0]   hi;
    logic [WAY_W-1:0]  way;
    logic [IDX_W-1:0]  idx;
    logic [LO_W-1:0]   lo;
  } hdr_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [SRC_W-1:0]  src;
    logic [WAY_W-1:0]  way;
    logic              instr;
    logic [LINE_W-1:0] line;
  } cln_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [SRC_W-1:0]  src;
    logic [IDX_W-1:0]  idx;
  } ack_t;

  typedef enum logic {S_HEAD, S_TAIL} rx_state_e;
endpackage

// File: rtl/cohrsp_fields.sv
module cohrsp_fields
  import cohrsp_pkg::*;
(
  input  logic [FLIT_W-1:0] flit,
  output hdr_t              hdr
);
  always_comb begin
    hdr.eop    = flit[EOP_POS];
    hdr.bc     = flit[BC_POS];
    hdr.is_cln = flit[TYPE_LSB+1];
    hdr.instr  = flit[TYPE_LSB];
    hdr.dest   = flit[DEST_LSB +: DEST_W];
    hdr.src    = flit[SRC_LSB +: SRC_W];
    hdr.hi     = flit[HI_LSB +: HI_W];
    hdr.way    = flit[WAY_LSB +: WAY_W];
    hdr.idx    = flit[IDX_LSB +: IDX_W];
    hdr.lo     = flit[LO_W-1:0];
  end
endmodule

// File: rtl/cohrsp_hold.sv
module cohrsp_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)                valid <= 1'b0;
    else if (load)          valid <= 1'b1;
    else if (valid && ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(dout));

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
endmodule

// File: rtl/cohrsp_rx.sv
module cohrsp_rx
  import cohrsp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FLIT_W-1:0]       in_flit,
  output logic                    cln_valid,
  input  logic                    cln_ready,
  output logic [DEST_W-1:0]       cln_dest,
  output logic [SRC_W-1:0]        cln_src,
  output logic [WAY_W-1:0]        cln_way,
  output logic                    cln_instr,
  output logic [LINE_W-1:0]       cln_line,
  output logic                    ack_valid,
  input  logic                    ack_ready,
  output logic [DEST_W-1:0]       ack_dest,
  output logic [SRC_W-1:0]        ack_src,
  output logic [IDX_W-1:0]        ack_idx,
  output logic                    err_flag
);
  localparam int CLN_BITS = $bits(cln_t);
  localparam int ACK_BITS = $bits(ack_t);

  hdr_t      hdr;
  rx_state_e state;
  logic      accept, cln_load, ack_load, err_set, to_tail;
  logic [DEST_W-1:0] pend_dest;
  logic [SRC_W-1:0]  pend_src;
  logic [WAY_W-1:0]  pend_way;
  logic [HI_W-1:0]   pend_hi;
  logic              pend_instr;
  cln_t cln_d, cln_q;
  ack_t ack_d, ack_q;

  cohrsp_fields i_fields (.flit(in_flit), .hdr(hdr));

  assign in_ready = !cln_valid && !ack_valid;
  assign accept   = in_valid && in_ready;

  always_comb begin
    cln_load = 1'b0;
    ack_load = 1'b0;
    err_set  = 1'b0;
    to_tail  = 1'b0;
    if (accept) begin
      if (state == S_HEAD) begin
        if (hdr.bc || (hdr.is_cln == hdr.eop)) err_set = 1'b1;
        else if (hdr.is_cln)                   to_tail = 1'b1;
        else                                   ack_load = 1'b1;
      end else begin
        if (hdr.eop) cln_load = 1'b1;
        else         err_set  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_HEAD;
      err_flag <= 1'b0;
    end else begin
      if (err_set) err_flag <= 1'b1;
      if (accept) state <= to_tail ? S_TAIL : S_HEAD;
    end
  end

  always_ff @(posedge clk) begin
    if (to_tail) begin
      pend_dest  <= hdr.dest;
      pend_src   <= hdr.src;
      pend_way   <= hdr.way;
      pend_hi    <= hdr.hi;
      pend_instr <= hdr.instr;
    end
  end

  always_comb begin
    cln_d.dest  = pend_dest;
    cln_d.src   = pend_src;
    cln_d.way   = pend_way;
    cln_d.instr = pend_instr;
    cln_d.line  = {pend_hi, hdr.lo};
    ack_d.dest  = hdr.dest;
    ack_d.src   = hdr.src;
    ack_d.idx   = hdr.idx;
  end

  cohrsp_hold #(.W(CLN_BITS)) i_cln_hold (
    .clk(clk), .rst(rst), .load(cln_load), .din(cln_d),
    .ready(cln_ready), .valid(cln_valid), .dout(cln_q)
  );

  cohrsp_hold #(.W(ACK_BITS)) i_ack_hold (
    .clk(clk), .rst(rst), .load(ack_load), .din(ack_d),
    .ready(ack_ready), .valid(ack_valid), .dout(ack_q)
  );

  assign cln_dest  = cln_q.dest;
  assign cln_src   = cln_q.src;
  assign cln_way   = cln_q.way;
  assign cln_instr = cln_q.instr;
  assign cln_line  = cln_q.line;
  assign ack_dest  = ack_q.dest;
  assign ack_src   = ack_q.src;
  assign ack_idx   = ack_q.idx;

  // R3
  cln_after_tail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cln_valid) |-> $past(state == S_TAIL && in_valid && in_flit[EOP_POS]));

  // R5
  stall_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (cln_valid || ack_valid) |-> !in_ready);

  // R5
  single_output_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cln_valid, ack_valid}));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R8
  bc_never_accepted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_valid) |-> !$past(in_flit[BC_POS]));
endmodule

// File: tb/test_cohrsp_rx.sv
module test_cohrsp_rx;
  logic        clk = 0, rst = 1;
  logic        in_valid = 0, cln_ready = 0, ack_ready = 0;
  logic [32:0] in_flit = '0;
  logic        in_ready, cln_valid, cln_instr, ack_valid, err_flag;
  logic [9:0]  cln_dest, ack_dest;
  logic [13:0] cln_src, ack_src;
  logic [1:0]  cln_way;
  logic [33:0] cln_line;
  logic [3:0]  ack_idx;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cohrsp_rx i_cohrsp_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .cln_valid(cln_valid), .cln_ready(cln_ready), .cln_dest(cln_dest), .cln_src(cln_src),
    .cln_way(cln_way), .cln_instr(cln_instr), .cln_line(cln_line),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_dest(ack_dest), .ack_src(ack_src),
    .ack_idx(ack_idx), .err_flag(err_flag)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [32:0] mk_head(logic [9:0] d, logic [13:0] s, logic [1:0] hi,
                                          logic [1:0] w, logic [1:0] t, logic eop, logic bc);
    return {eop, d, s, hi, 1'b0, w, t, bc};
  endfunction

  function automatic logic [32:0] mk_ack(logic [9:0] d, logic [13:0] s, logic [3:0] ix,
                                         logic [1:0] t, logic eop, logic bc);
    return {eop, d, s, 1'b0, ix, t, bc};
  endfunction

  task automatic send(logic [32:0] f);
    @(negedge clk);
    in_valid = 1; in_flit = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_flit = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; cln_ready = 0; ack_ready = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic release_cln();
    cln_ready = 1; @(negedge clk); cln_ready = 0;
  endtask

  task automatic release_ack();
    ack_ready = 1; @(negedge clk); ack_ready = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 cln_valid", cln_valid, 0);
    check("R1 ack_valid", ack_valid, 0);
    check("R1 err_flag", err_flag, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_cleanup_data();
    do_reset();
    send(mk_head(10'h2A5, 14'h1234, 2'b10, 2'b01, 2'b10, 0, 0));
    check("R3 no early valid", cln_valid, 0);
    repeat (3) @(negedge clk);
    check("R3 still not valid", cln_valid, 0);
    send({1'b1, 32'hDEADBEEE});
    check("R2 valid", cln_valid, 1);
    check("R2 dest", cln_dest, 10'h2A5);
    check("R2 src", cln_src, 14'h1234);
    check("R2 way", cln_way, 2'b01);
    check("R2 data kind", cln_instr, 0);
    check("R2 line", cln_line, {2'b10, 32'hDEADBEEE});
    repeat (3) @(negedge clk);
    check("R5 held valid", cln_valid, 1);
    check("R5 held line", cln_line, {2'b10, 32'hDEADBEEE});
    check("R5 stall", in_ready, 0);
    release_cln();
    check("R5 released", cln_valid, 0);
    check("R5 ready again", in_ready, 1);
    check("R2 no error", err_flag, 0);
  endtask

  task automatic t_cleanup_instr();
    do_reset();
    send(mk_head(10'h001, 14'h3FFF, 2'b01, 2'b11, 2'b11, 0, 0));
    send({1'b1, 32'h00000001});
    check("R2 instr kind", cln_instr, 1);
    check("R2 way3", cln_way, 2'b11);
    check("R8 tail bit0 is data", cln_line, {2'b01, 32'h00000001});
    check("R8 tail bit0 no error", err_flag, 0);
    release_cln();
  endtask

  task automatic t_ack();
    do_reset();
    send(mk_ack(10'h155, 14'h2AAA, 4'hC, 2'b01, 1, 0));
    check("R4 valid", ack_valid, 1);
    check("R4 dest", ack_dest, 10'h155);
    check("R4 src", ack_src, 14'h2AAA);
    check("R4 idx", ack_idx, 4'hC);
    check("R4 no cleanup", cln_valid, 0);
    repeat (2) @(negedge clk);
    check("R5 ack held", ack_idx, 4'hC);
    check("R5 ack stall", in_ready, 0);
    release_ack();
    send(mk_ack(10'h0F0, 14'h0003, 4'h5, 2'b00, 1, 0));
    check("R4 type00 idx", ack_idx, 4'h5);
    check("R4 type00 dest", ack_dest, 10'h0F0);
    release_ack();
  endtask

  task automatic t_err_head_eop();
    do_reset();
    send(mk_head(10'h011, 14'h0022, 2'b11, 2'b10, 2'b10, 1, 0));
    check("R6 err", err_flag, 1);
    check("R6 no cleanup", cln_valid, 0);
    send(mk_ack(10'h033, 14'h0044, 4'h9, 2'b00, 1, 0));
    check("R6 next is header", ack_idx, 4'h9);
    check("R6 ack valid", ack_valid, 1);
    release_ack();
    repeat (4) @(negedge clk);
    check("R10 sticky", err_flag, 1);
  endtask

  task automatic t_err_ack_noeop();
    do_reset();
    send(mk_ack(10'h066, 14'h0077, 4'h3, 2'b00, 0, 0));
    check("R7 err", err_flag, 1);
    check("R7 no ack", ack_valid, 0);
    check("R7 no cleanup", cln_valid, 0);
  endtask

  task automatic t_err_bc();
    do_reset();
    send(mk_ack(10'h066, 14'h0077, 4'h3, 2'b00, 1, 1));
    check("R8 err", err_flag, 1);
    check("R8 no ack", ack_valid, 0);
    send(mk_ack(10'h001, 14'h0002, 4'hA, 2'b00, 1, 0));
    check("R8 recovers", ack_idx, 4'hA);
    release_ack();
  endtask

  task automatic t_err_tail();
    do_reset();
    send(mk_head(10'h3FF, 14'h0001, 2'b00, 2'b00, 2'b10, 0, 0));
    send({1'b0, 32'h12345678});
    check("R9 err", err_flag, 1);
    check("R9 no cleanup", cln_valid, 0);
    send(mk_ack(10'h010, 14'h0020, 4'h7, 2'b00, 1, 0));
    check("R9 next is header", ack_valid, 1);
    check("R9 idx", ack_idx, 4'h7);
    release_ack();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cleanup_data();
    t_cleanup_instr();
    t_ack();
    t_err_head_eop();
    t_err_ack_noeop();
    t_err_bc();
    t_err_tail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule